// File: doc/BRIEF.md
# Packet-Synchronized Video Stream Crossbar

This block routes N streaming video inputs to N streaming video outputs. Every stream uses a valid/ready handshake with start-of-packet and end-of-packet flags. Each beat carries several pixels side by side. Each output takes its beats from exactly one selected input, and one input may feed any number of outputs. Streams are never merged.

Software programs the routing through a small register port. Each output has an input select. Each input has an enable bit and a mode bit. The mode bit decides whether a disabled input is held off or quietly drained. All of these registers are shadows. The routing logic copies them only while the crossbar is stopped. Stopping lets every input that is inside a packet run on to that packet's end-of-packet beat. After that, no enabled input accepts new data, so all streams halt at a packet boundary. A reload can be done by hand, by clearing the run bit, polling status and setting the run bit again. It can also be done with a single auto-switch command that stops, reloads and resumes without further software action.

Top module: `vstream_xbar`

## Requirements
- R1: Output k presents the valid, data, start and end flags of the input named by its active select, in the same cycle, with no register stage in between.
- R2: An enabled input shows ready only when every output whose active select names it is ready. A beat from that input is shown as valid on all of those outputs together, in the cycle in which it is accepted.
- R3: A disabled input in stall mode (mode bit 0) keeps ready low, and its beats never reach any output. An output whose select names a disabled input shows no valid.
- R4: A disabled input in consume mode (mode bit 1) keeps ready high, and its beats are discarded.
- R5: Register writes made while the crossbar is running or draining do not change the routing in use.
- R6: When the run bit is cleared, an input that is inside a packet keeps forwarding through its end-of-packet beat. An enabled input that is not inside a packet shows ready low and does not start a new packet.
- R7: Status (address 1, bit 0) reads 1 while the effective run bit is set or any enabled input is inside a packet. It reads 0 otherwise. The effective run bit is the run bit with a pending auto-switch masked out.
- R8: While status is 0, the shadow registers are copied into the active routing every cycle. Setting the run bit then resumes forwarding with the new routing.
- R9: Writing 1 to the auto-switch bit (address 2, bit 0) stops the crossbar at packet boundaries, loads the shadows and resumes. The bit clears by itself in the cycle the load happens.
- R10: Register map: address 0 bit 0 is the run bit; address 1 is status (read only); address 2 is auto-switch; address 3 holds one enable bit per input; address 4 holds one mode bit per input; address 8+k holds the input select of output k. All registers reset to 0.
- R11: The port count, pixels per beat and bits per pixel are parameters. The data width is pixels per beat times bits per pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 5 | Register address |
| csr_wdata | input | N | Register write data |
| csr_rdata | output | N | Register read data, combinational from csr_addr |
| in_valid | input | N | Per-input valid |
| in_ready | output | N | Per-input ready |
| in_sop | input | N | Per-input start of packet |
| in_eop | input | N | Per-input end of packet |
| in_data | input | N*DW | Per-input beat data, input i at bits i*DW upward |
| out_valid | output | N | Per-output valid |
| out_ready | input | N | Per-output ready |
| out_sop | output | N | Per-output start of packet |
| out_eop | output | N | Per-output end of packet |
| out_data | output | N*DW | Per-output beat data |

## Verification
The routing is tried with packets on two inputs, each fanned out to two outputs. This separates a correct select from a swapped or shared one. Holding back one output of a fan-out group shows whether the input waits for the whole group or leaks duplicate beats to its partners. A packet that is cut by a stop or an auto-switch in mid-flight shows whether draining ends exactly at the end-of-packet beat and whether the new routing is applied only after that beat. Stalled and consumed inputs are driven with live data, which shows that their ready levels are correct and that nothing leaks onto the outputs.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  // register addresses
  localparam logic [4:0] A_RUN  = 5'd0;
  localparam logic [4:0] A_STAT = 5'd1;
  localparam logic [4:0] A_AUTO = 5'd2;
  localparam logic [4:0] A_EN   = 5'd3;
  localparam logic [4:0] A_MODE = 5'd4;
  localparam int         A_SEL  = 8;

  function automatic int sel_bits(int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // address of the select register for output k
  function automatic logic [4:0] sel_addr(int k);
    return 5'(A_SEL + k);
  endfunction
endpackage

// File: rtl/xbar_csr.sv
module xbar_csr #(
  parameter int N  = 4,
  parameter int SW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [4:0]      addr,
  input  logic [N-1:0]    wdata,
  input  logic            status,
  output logic [N-1:0]    rdata,
  output logic            run_q,
  output logic            auto_q,
  output logic            load,
  output logic [N-1:0]    act_en,
  output logic [N-1:0]    act_mode,
  output logic [N*SW-1:0] act_sel
);
  import xbar_pkg::*;

  logic [N-1:0]    sh_en, sh_mode;
  logic [N*SW-1:0] sh_sel;

  assign load = ~status;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0; auto_q <= 1'b0;
      sh_en <= '0; sh_mode <= '0; sh_sel <= '0;
      act_en <= '0; act_mode <= '0; act_sel <= '0;
    end else begin
      if (load && auto_q) auto_q <= 1'b0;
      if (wr) begin
        if (addr == A_RUN)  run_q  <= wdata[0];
        if (addr == A_AUTO) auto_q <= wdata[0];
        if (addr == A_EN)   sh_en   <= wdata;
        if (addr == A_MODE) sh_mode <= wdata;
        for (int k = 0; k < N; k++)
          if (addr == sel_addr(k)) sh_sel[k*SW +: SW] <= wdata[SW-1:0];
      end
      if (load) begin
        act_en <= sh_en; act_mode <= sh_mode; act_sel <= sh_sel;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_RUN)  rdata[0] = run_q;
    if (addr == A_STAT) rdata[0] = status;
    if (addr == A_AUTO) rdata[0] = auto_q;
    if (addr == A_EN)   rdata = sh_en;
    if (addr == A_MODE) rdata = sh_mode;
    for (int k = 0; k < N; k++)
      if (addr == sel_addr(k)) rdata[SW-1:0] = sh_sel[k*SW +: SW];
  end
endmodule

// File: rtl/xbar_sync.sv
module xbar_sync #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_q,
  input  logic         auto_q,
  input  logic [N-1:0] acc,
  input  logic [N-1:0] acc_eop,
  output logic [N-1:0] gate,
  output logic [N-1:0] in_pkt,
  output logic         status
);
  logic eff_run;

  assign eff_run = run_q & ~auto_q;
  assign gate    = {N{eff_run}} | in_pkt;
  assign status  = eff_run | (|in_pkt);

  // an accepted beat leaves the input inside a packet unless it ends one
  always_ff @(posedge clk) begin
    if (!rst_n) in_pkt <= '0;
    else
      for (int i = 0; i < N; i++)
        if (acc[i]) in_pkt[i] <= ~acc_eop[i];
  end
endmodule

// File: rtl/xbar_route.sv
module xbar_route #(
  parameter int N  = 4,
  parameter int SW = 2,
  parameter int DW = 16
) (
  input  logic [N-1:0]    in_valid,
  input  logic [N-1:0]    in_sop,
  input  logic [N-1:0]    in_eop,
  input  logic [N*DW-1:0] in_data,
  output logic [N-1:0]    in_ready,
  input  logic [N-1:0]    out_ready,
  output logic [N-1:0]    out_valid,
  output logic [N-1:0]    out_sop,
  output logic [N-1:0]    out_eop,
  output logic [N*DW-1:0] out_data,
  input  logic [N-1:0]    act_en,
  input  logic [N-1:0]    act_mode,
  input  logic [N*SW-1:0] act_sel,
  input  logic [N-1:0]    gate,
  output logic [N-1:0]    acc
);
  logic [N-1:0] fan_rdy;

  // ready of an input: all outputs selecting it must be ready
  always_comb begin
    for (int i = 0; i < N; i++) begin
      fan_rdy[i] = 1'b1;
      for (int k = 0; k < N; k++)
        if (act_sel[k*SW +: SW] == SW'(i) && !out_ready[k]) fan_rdy[i] = 1'b0;
      in_ready[i] = act_en[i] ? (gate[i] & fan_rdy[i]) : act_mode[i];
    end
  end

  assign acc = in_valid & in_ready & act_en;

  for (genvar k = 0; k < N; k++) begin : g_out
    logic [SW-1:0] s;
    assign s = act_sel[k*SW +: SW];
    always_comb begin
      out_valid[k] = 1'b0; out_sop[k] = 1'b0; out_eop[k] = 1'b0;
      out_data[k*DW +: DW] = '0;
      for (int i = 0; i < N; i++)
        if (s == SW'(i)) begin
          out_valid[k] = acc[i];
          out_sop[k]   = in_sop[i];
          out_eop[k]   = in_eop[i];
          out_data[k*DW +: DW] = in_data[i*DW +: DW];
        end
    end
  end
endmodule

// File: rtl/vstream_xbar.sv
module vstream_xbar #(
  parameter int N            = 4,
  parameter int PIX_PER_BEAT = 2,
  parameter int PIX_BITS     = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               csr_wr,
  input  logic [4:0]                         csr_addr,
  input  logic [N-1:0]                       csr_wdata,
  output logic [N-1:0]                       csr_rdata,
  input  logic [N-1:0]                       in_valid,
  output logic [N-1:0]                       in_ready,
  input  logic [N-1:0]                       in_sop,
  input  logic [N-1:0]                       in_eop,
  input  logic [N*PIX_PER_BEAT*PIX_BITS-1:0] in_data,
  output logic [N-1:0]                       out_valid,
  input  logic [N-1:0]                       out_ready,
  output logic [N-1:0]                       out_sop,
  output logic [N-1:0]                       out_eop,
  output logic [N*PIX_PER_BEAT*PIX_BITS-1:0] out_data
);
  localparam int DW = PIX_PER_BEAT * PIX_BITS;
  localparam int SW = xbar_pkg::sel_bits(N);

  logic            run_q, auto_q, load, status;
  logic [N-1:0]    act_en, act_mode, gate, in_pkt, acc;
  logic [N*SW-1:0] act_sel;

  xbar_csr #(.N(N), .SW(SW)) u_csr (
    .clk(clk), .rst_n(rst_n), .wr(csr_wr), .addr(csr_addr), .wdata(csr_wdata),
    .status(status), .rdata(csr_rdata), .run_q(run_q), .auto_q(auto_q),
    .load(load), .act_en(act_en), .act_mode(act_mode), .act_sel(act_sel)
  );

  xbar_sync #(.N(N)) u_sync (
    .clk(clk), .rst_n(rst_n), .run_q(run_q), .auto_q(auto_q),
    .acc(acc), .acc_eop(in_eop), .gate(gate), .in_pkt(in_pkt), .status(status)
  );

  xbar_route #(.N(N), .SW(SW), .DW(DW)) u_route (
    .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
    .in_ready(in_ready), .out_ready(out_ready), .out_valid(out_valid),
    .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data),
    .act_en(act_en), .act_mode(act_mode), .act_sel(act_sel), .gate(gate), .acc(acc)
  );
endmodule

// File: rtl/xbar_chk.sv
module xbar_chk #(
  parameter int N  = 4,
  parameter int SW = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            csr_wr,
  input logic [4:0]      csr_addr,
  input logic [N-1:0]    csr_wdata,
  input logic            status,
  input logic            auto_q,
  input logic [N-1:0]    act_en,
  input logic [N-1:0]    act_mode,
  input logic [N*SW-1:0] act_sel,
  input logic [N-1:0]    in_ready,
  input logic [N-1:0]    out_valid
);
  // R3
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((in_ready & ~act_en & ~act_mode) == '0));
  // R4
  consume_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~in_ready & ~act_en & act_mode) == '0));
  // R5
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status |=> ($stable(act_sel) && $stable(act_en) && $stable(act_mode)));
  // R6
  stopped_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !status |-> ((in_ready & act_en) == '0));
  // R6
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !status |-> (out_valid == '0));
  // R9
  auto_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_q && !status && !(csr_wr && csr_addr == 5'd2 && csr_wdata[0])) |=> !auto_q);
endmodule

bind vstream_xbar xbar_chk #(.N(N), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
  .csr_wdata(csr_wdata), .status(status), .auto_q(auto_q), .act_en(act_en),
  .act_mode(act_mode), .act_sel(act_sel), .in_ready(in_ready), .out_valid(out_valid)
);

// File: tb/vstream_xbar_tb.sv
module vstream_xbar_tb;
  localparam int N = 4;
  localparam int DW = 16;

  logic clk = 0, rst_n = 0;
  logic csr_wr = 0;
  logic [4:0] csr_addr = 0;
  logic [N-1:0] csr_wdata = 0, csr_rdata;
  logic [N-1:0] in_valid, in_ready, in_sop, in_eop;
  logic [N*DW-1:0] in_data, out_data;
  logic [N-1:0] out_valid, out_sop, out_eop;
  logic [N-1:0] out_ready = '1;

  logic tv [N];
  logic ts [N];
  logic te [N];
  logic [DW-1:0] td [N];

  int checks = 0, fails = 0;
  string cur_req = "R1";
  int m_sel [N];
  logic m_en [N];
  logic [DW+1:0] expq [N][$];

  always #10 clk = ~clk;

  always_comb
    for (int i = 0; i < N; i++) begin
      in_valid[i] = tv[i]; in_sop[i] = ts[i]; in_eop[i] = te[i];
      in_data[i*DW +: DW] = td[i];
    end

  vstream_xbar #(.N(N), .PIX_PER_BEAT(2), .PIX_BITS(8)) u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pop expected beats as outputs transfer
  always @(negedge clk) if (rst_n)
    for (int k = 0; k < N; k++)
      if (out_valid[k] && out_ready[k]) begin
        checks++;
        if (expq[k].size() == 0) begin
          fails++;
          $display("FAIL %s out%0d unexpected actual=%h expected=none", cur_req, k,
                   {out_sop[k], out_eop[k], out_data[k*DW +: DW]});
        end else begin
          logic [DW+1:0] e;
          e = expq[k].pop_front();
          if ({out_sop[k], out_eop[k], out_data[k*DW +: DW]} !== e) begin
            fails++;
            $display("FAIL %s out%0d actual=%h expected=%h", cur_req, k,
                     {out_sop[k], out_eop[k], out_data[k*DW +: DW]}, e);
          end
        end
      end

  task automatic wr(input logic [4:0] a, input logic [N-1:0] d);
    csr_wr = 1; csr_addr = a; csr_wdata = d;
    @(posedge clk); #1 csr_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [N-1:0] d);
    csr_addr = a; #1 d = csr_rdata;
  endtask

  // driver: one packet on input i, pushing expected beats per the bench model
  task automatic send(input int i, input int len, input logic [7:0] base);
    for (int b = 0; b < len; b++) begin
      tv[i] = 1; ts[i] = (b == 0); te[i] = (b == len - 1);
      td[i] = {base, 8'(b)};
      for (int k = 0; k < N; k++)
        if (m_en[i] && m_sel[k] == i) expq[k].push_back({ts[i], te[i], td[i]});
      forever begin
        @(negedge clk);
        if (in_ready[i]) break;
      end
      @(posedge clk); #1;
    end
    tv[i] = 0; ts[i] = 0; te[i] = 0;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic finish_up();
    for (int k = 0; k < N; k++) chk("R1 queue drained", 32'(expq[k].size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      tv[i] = 0; ts[i] = 0; te[i] = 0; td[i] = 0; m_sel[i] = 0; m_en[i] = 0;
    end
    repeat (4) @(posedge clk); #1 rst_n = 1;
    // R10 reset state
    rd(xbar_pkg::A_STAT, r); chk("R7 status after reset", 32'(r), 0);
    rd(xbar_pkg::A_EN, r);   chk("R10 enable after reset", 32'(r), 0);
    chk("R10 outputs idle after reset", 32'(out_valid), 0);
    chk("R3 stall after reset", 32'(in_ready), 0);

    // config: in0,in1 enabled, in2 consume, in3 stall; out0/2<-in0, out1/3<-in1
    wr(xbar_pkg::A_EN, 4'b0011);
    wr(xbar_pkg::A_MODE, 4'b0100);
    wr(xbar_pkg::sel_addr(0), 0); wr(xbar_pkg::sel_addr(1), 1);
    wr(xbar_pkg::sel_addr(2), 0); wr(xbar_pkg::sel_addr(3), 1);
    rd(xbar_pkg::sel_addr(3), r); chk("R10 select readback", 32'(r), 1);
    m_en[0] = 1; m_en[1] = 1; m_sel[0] = 0; m_sel[1] = 1; m_sel[2] = 0; m_sel[3] = 1;
    wr(xbar_pkg::A_RUN, 1);
    rd(xbar_pkg::A_STAT, r); chk("R7 status while running", 32'(r), 1);

    // R1 / R11: routing of two-pixel beats
    cur_req = "R1"; send(0, 4, 8'hA0); send(1, 3, 8'hB1); settle();

    // R2: hold back one output of a fan-out pair
    cur_req = "R2"; out_ready[2] = 0;
    tv[0] = 1; ts[0] = 1; te[0] = 0; td[0] = 16'hC000;
    #1 chk("R2 input waits for all its outputs", 32'(in_ready[0]), 0);
    chk("R2 no partial delivery", 32'(out_valid[0]), 0);
    @(posedge clk); #1 tv[0] = 0; ts[0] = 0;
    fork
      send(0, 4, 8'hC1);
      begin repeat (2) @(posedge clk); #1 out_ready[2] = 1; end
    join
    settle();

    // R3 / R4: disabled inputs
    cur_req = "R3"; tv[3] = 1; ts[3] = 1; te[3] = 1; td[3] = 16'hDEAD;
    tv[2] = 1; ts[2] = 1; te[2] = 1; td[2] = 16'hBEEF;
    repeat (3) @(posedge clk); #1;
    chk("R3 stalled input ready low", 32'(in_ready[3]), 0);
    chk("R4 consumed input ready high", 32'(in_ready[2]), 1);
    chk("R3 R4 nothing on outputs", 32'(out_valid), 0);
    tv[3] = 0; tv[2] = 0; ts[2] = 0; te[2] = 0; ts[3] = 0; te[3] = 0;

    // R5: shadow write while running has no effect
    cur_req = "R5"; wr(xbar_pkg::sel_addr(0), 1);
    send(0, 3, 8'hE0); settle();

    // R6: stop in mid-packet
    cur_req = "R6";
    fork
      send(0, 6, 8'hF0);
      begin repeat (2) @(posedge clk); #1 wr(xbar_pkg::A_RUN, 0); end
    join
    rd(xbar_pkg::A_STAT, r); chk("R7 status after drain", 32'(r), 0);
    tv[1] = 1; ts[1] = 1; td[1] = 16'h1234;
    #1 chk("R6 no new packet while stopped", 32'(in_ready[1]), 0);
    @(posedge clk); #1;
    chk("R6 outputs quiet while stopped", 32'(out_valid), 0);
    tv[1] = 0; ts[1] = 0;

    // R8: manual reload picks up the shadow select out0<-in1
    cur_req = "R8"; m_sel[0] = 1;
    wr(xbar_pkg::A_RUN, 1);
    send(1, 3, 8'h21); send(0, 2, 8'h20); settle();

    // R9: auto-switch during a packet, new out3<-in0
    cur_req = "R9"; wr(xbar_pkg::sel_addr(3), 0);
    fork
      send(1, 6, 8'h31);
      begin repeat (2) @(posedge clk); #1 wr(xbar_pkg::A_AUTO, 1); end
    join
    settle();
    rd(xbar_pkg::A_AUTO, r); chk("R9 auto bit self-clears", 32'(r), 0);
    rd(xbar_pkg::A_STAT, r); chk("R9 resumed running", 32'(r), 1);
    m_sel[3] = 0;
    send(0, 3, 8'h30); send(1, 2, 8'h32); settle();

    finish_up();
  end
endmodule